// File: doc/BRIEF.md
# Nibble-Interleaved DRAM Slot Sequencer

This block drives a byte-wide memory built from dynamic RAM parts that move only four bits at a time. Time is divided into slots of eight clock cycles. In each slot the block does at most one byte access for one of two masters, the video fetcher or the CPU. An access opens a row with one falling row strobe. Two falling column strobes follow in page mode: the first moves the low nibble of the byte and the second moves the high nibble. Row and column share one multiplexed address bus. Read nibbles are joined into a byte, which is returned with a one-cycle valid pulse and a tag naming the master that asked for it.

Each master has a valid/ready request port. A master raises valid with a stable payload and holds it until ready is seen high. Ready is offered only in the last cycle of a slot, and only to the master that owns the next slot, so a master that is not granted simply waits. Which master owns a slot depends on the display mode and on whether the line is in its active part. In the narrow mode video and CPU take turns. In the wide mode video takes every slot. Outside the active part of a line, or with no display, the CPU takes every slot. The read return has no ready signal, because the memory cannot be paused: a master must accept the byte in the cycle it is offered.

Top module: `nibble_dram_seq`

## Requirements
- R1: A serviced slot lasts 8 cycles, counted 0 to 7 from the cycle after the handshake. `dram_ras_n` is low in cycles 1 to 5 and high in cycles 0, 6 and 7.
- R2: `dram_cas_n` is low only in cycles 3 and 5 of a serviced slot, so it falls exactly twice while the row is open. It is never low while `dram_ras_n` is high.
- R3: The byte address is 15 bits wide. `dram_a` carries the row, address bits 14..7, in cycles 0 and 1. It carries the column {address bits 6..0, 0} in cycles 2 and 3, and the column {address bits 6..0, 1} from cycle 4 on. The address has the same value in the cycle before each strobe falls as in the cycle where it falls.
- R4: For a read, `dram_dq_i` is sampled at the end of cycle 4 as the low nibble and at the end of cycle 6 as the high nibble. `rd_valid` is high in cycle 7 only, with `rd_data` = {high, low}. `rd_owner` is 0 for video and 1 for CPU.
- R5: With `mode` = 01 (narrow) and `line_active` high, slots alternate between video and CPU, and the first slot after reset belongs to video.
- R6: With `mode` = 10 or 11 (wide) and `line_active` high, every slot belongs to video and `cpu_ready` stays low.
- R7: With `mode` = 00 (no display), or with `line_active` low, every slot belongs to the CPU and `vid_ready` stays low.
- R8: For a CPU write, `dram_we_n` is low in cycles 1 to 6. `dram_dq_oe` is high in cycles 2 to 5. `dram_dq_o` holds the low nibble of the write data in cycles 2 and 3 and the high nibble in cycles 4 and 5. No `rd_valid` follows a write. `dram_we_n` does not change while the row is open.
- R9: A ready is one cycle long and appears only in the last cycle of a slot, for the master that owns the next slot. A slot whose owner has no valid request produces no strobes.
- R10: During reset, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are high, and `dram_dq_oe` and `rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, eight cycles per slot |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 00 no display, 01 narrow (shared), 10/11 wide (video only) |
| line_active | input | 1 | High during the pixel-fetch part of a line |
| vid_valid | input | 1 | Video read request valid |
| vid_ready | output | 1 | Video request accepted at the coming edge |
| vid_addr | input | 15 | Video byte address |
| cpu_valid | input | 1 | CPU request valid |
| cpu_ready | output | 1 | CPU request accepted at the coming edge |
| cpu_addr | input | 15 | CPU byte address |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_wdata | input | 8 | CPU write byte |
| rd_valid | output | 1 | One-cycle pulse, read byte present |
| rd_owner | output | 1 | Master of the returned byte, 0 video, 1 CPU |
| rd_data | output | 8 | Joined read byte |
| dram_a | output | 8 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Active-low row strobe |
| dram_cas_n | output | 1 | Active-low column strobe |
| dram_we_n | output | 1 | Active-low write enable |
| dram_dq_oe | output | 1 | Drive enable for the nibble data lines |
| dram_dq_o | output | 4 | Write nibble |
| dram_dq_i | input | 4 | Read nibble |

## Verification
The assertions assume that a master keeps its payload steady from the moment it raises valid until the ready it waits for. They also assume that the memory side has settled `dram_dq_i` by the end of cycles 4 and 6 of a read slot. The bench tasks change a payload only in the cycle after a handshake. The bench memory model drives the addressed nibble at each falling column strobe and holds it until the next one, so both sampling points see settled data. That model also checks strobe order and address stability on every access, whichever master started it.

// File: rtl/dseq_pkg.sv
package dseq_pkg;
  localparam int SLOT_CYC = 8;
  localparam int PH_W     = $clog2(SLOT_CYC);

  typedef enum logic {OWN_VID = 1'b0, OWN_CPU = 1'b1} owner_e;

  typedef enum logic [1:0] {
    DM_NONE   = 2'b00,
    DM_NARROW = 2'b01,
    DM_WIDE   = 2'b10,
    DM_WIDE2  = 2'b11
  } dmode_e;

  // slot cycle positions; the strobe order depends on them
  localparam logic [PH_W-1:0] PH_ROW  = 3'd0;
  localparam logic [PH_W-1:0] PH_RAS  = 3'd1;
  localparam logic [PH_W-1:0] PH_COL0 = 3'd2;
  localparam logic [PH_W-1:0] PH_CAS0 = 3'd3;
  localparam logic [PH_W-1:0] PH_COL1 = 3'd4;
  localparam logic [PH_W-1:0] PH_CAS1 = 3'd5;
  localparam logic [PH_W-1:0] PH_DONE = 3'd6;
  localparam logic [PH_W-1:0] PH_LAST = 3'd7;
endpackage

// File: rtl/dseq_slot_ctl.sv
module dseq_slot_ctl
  import dseq_pkg::*;
#(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  dmode_e          mode,
  input  logic            line_active,
  input  logic            vid_valid,
  input  logic [AW-1:0]   vid_addr,
  input  logic            cpu_valid,
  input  logic [AW-1:0]   cpu_addr,
  input  logic            cpu_we,
  input  logic [DW-1:0]   cpu_wdata,
  output logic            vid_ready,
  output logic            cpu_ready,
  output logic [PH_W-1:0] ph,
  output logic            d_v,
  output logic            d_we,
  output logic [AW-1:0]   d_addr,
  output logic [DW-1:0]   d_wdata,
  output owner_e          d_own,
  output logic            q_v,
  output logic            q_we,
  output logic [AW-1:0]   q_addr,
  output logic [DW-1:0]   q_wdata,
  output owner_e          q_own
);
  logic   odd_q;
  owner_e nxt_own;
  logic   at_edge;

  assign at_edge = (ph == PH_LAST);

  // phase counter starts at the last cycle so the first edge opens a slot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph    <= PH_LAST;
      odd_q <= 1'b1;
    end else begin
      ph <= ph + 1'b1;
      if (at_edge) odd_q <= ~odd_q;
    end
  end

  // owner of the slot that begins at the coming edge
  always_comb begin
    unique case (mode)
      DM_NONE:   nxt_own = OWN_CPU;
      DM_NARROW: nxt_own = (!line_active || odd_q == 1'b0) ? OWN_CPU : OWN_VID;
      default:   nxt_own = line_active ? OWN_VID : OWN_CPU;
    endcase
  end

  assign vid_ready = at_edge && (nxt_own == OWN_VID);
  assign cpu_ready = at_edge && (nxt_own == OWN_CPU);

  always_comb begin
    d_own   = nxt_own;
    d_v     = (vid_ready && vid_valid) || (cpu_ready && cpu_valid);
    d_we    = cpu_ready && cpu_valid && cpu_we;
    d_addr  = (nxt_own == OWN_CPU) ? cpu_addr : vid_addr;
    d_wdata = cpu_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_v     <= 1'b0;
      q_we    <= 1'b0;
      q_addr  <= '0;
      q_wdata <= '0;
      q_own   <= OWN_VID;
    end else if (at_edge) begin
      q_v     <= d_v;
      q_we    <= d_we;
      q_addr  <= d_addr;
      q_wdata <= d_wdata;
      q_own   <= d_own;
    end
  end

  a_r6_wide_locks_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    (line_active && mode[1]) |-> !cpu_ready);
  a_r7_no_video_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_active || mode == DM_NONE) |-> !vid_ready);
  a_r9_cpu_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);
  a_r9_vid_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
    vid_ready |=> !vid_ready);
endmodule

// File: rtl/dseq_strobe_gen.sv
module dseq_strobe_gen
  import dseq_pkg::*;
#(
  parameter int ROW_W = 8,
  parameter int COL_W = 8,
  parameter int NIB_W = 4,
  localparam int AW   = ROW_W + COL_W - 1,
  localparam int DW   = 2 * NIB_W,
  localparam int MA_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PH_W-1:0]  ph,
  input  logic             d_v,
  input  logic             d_we,
  input  logic [AW-1:0]    d_addr,
  input  logic [DW-1:0]    d_wdata,
  input  logic             q_v,
  input  logic             q_we,
  input  logic [AW-1:0]    q_addr,
  input  logic [DW-1:0]    q_wdata,
  output logic [MA_W-1:0]  dram_a,
  output logic             dram_ras_n,
  output logic             dram_cas_n,
  output logic             dram_we_n,
  output logic             dram_dq_oe,
  output logic [NIB_W-1:0] dram_dq_o
);
  logic [PH_W-1:0]  ph_n;
  logic             s_v, s_we;
  logic [AW-1:0]    s_addr;
  logic [DW-1:0]    s_wd;
  logic [MA_W-1:0]  row_a, col0_a, col1_a;
  logic [MA_W-1:0]  a_d;
  logic             ras_d, cas_d, we_d, oe_d;
  logic [NIB_W-1:0] dq_d;

  assign ph_n   = ph + 1'b1;
  // at the slot edge the fresh request is the one that steers cycle 0
  assign s_v    = (ph == PH_LAST) ? d_v     : q_v;
  assign s_we   = (ph == PH_LAST) ? d_we    : q_we;
  assign s_addr = (ph == PH_LAST) ? d_addr  : q_addr;
  assign s_wd   = (ph == PH_LAST) ? d_wdata : q_wdata;

  assign row_a  = MA_W'(s_addr[AW-1:COL_W-1]);
  assign col0_a = MA_W'({s_addr[COL_W-2:0], 1'b0});
  assign col1_a = MA_W'({s_addr[COL_W-2:0], 1'b1});

  always_comb begin
    a_d   = dram_a;
    ras_d = 1'b1;
    cas_d = 1'b1;
    we_d  = 1'b1;
    oe_d  = 1'b0;
    dq_d  = dram_dq_o;
    if (s_v) begin
      unique case (ph_n)
        PH_ROW: a_d = row_a;
        PH_RAS: begin
          a_d = row_a; ras_d = 1'b0; we_d = ~s_we;
        end
        PH_COL0, PH_CAS0: begin
          a_d = col0_a; ras_d = 1'b0; we_d = ~s_we; oe_d = s_we;
          cas_d = (ph_n != PH_CAS0);
          dq_d = s_wd[NIB_W-1:0];
        end
        PH_COL1, PH_CAS1: begin
          a_d = col1_a; ras_d = 1'b0; we_d = ~s_we; oe_d = s_we;
          cas_d = (ph_n != PH_CAS1);
          dq_d = s_wd[DW-1:NIB_W];
        end
        PH_DONE: we_d = ~s_we;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dram_a     <= '0;
      dram_ras_n <= 1'b1;
      dram_cas_n <= 1'b1;
      dram_we_n  <= 1'b1;
      dram_dq_oe <= 1'b0;
      dram_dq_o  <= '0;
    end else begin
      dram_a     <= a_d;
      dram_ras_n <= ras_d;
      dram_cas_n <= cas_d;
      dram_we_n  <= we_d;
      dram_dq_oe <= oe_d;
      dram_dq_o  <= dq_d;
    end
  end

  a_r2_cas_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> !dram_ras_n);
  a_r3_row_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> $stable(dram_a));
  a_r3_col_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_cas_n) |-> $stable(dram_a));
  a_r8_we_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_ras_n && $past(!dram_ras_n)) |-> $stable(dram_we_n));
  a_r1_ras_one_per_slot: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> (ph == PH_RAS));
endmodule

// File: rtl/dseq_nibble_join.sv
module dseq_nibble_join
  import dseq_pkg::*;
#(
  parameter int NIB_W = 4,
  localparam int DW   = 2 * NIB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PH_W-1:0]  ph,
  input  logic             q_v,
  input  logic             q_we,
  input  owner_e           q_own,
  input  logic [NIB_W-1:0] dq_i,
  output logic             rd_valid,
  output owner_e           rd_owner,
  output logic [DW-1:0]    rd_data
);
  logic [NIB_W-1:0] lo_q;
  logic             is_rd;

  assign is_rd = q_v && !q_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q     <= '0;
      rd_valid <= 1'b0;
      rd_owner <= OWN_VID;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (is_rd && ph == PH_COL1) lo_q <= dq_i;
      if (is_rd && ph == PH_DONE) begin
        rd_valid <= 1'b1;
        rd_owner <= q_own;
        rd_data  <= {dq_i, lo_q};
      end
    end
  end

  a_r4_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  a_r4_valid_at_slot_end: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (ph == PH_LAST));
endmodule

// File: rtl/nibble_dram_seq.sv
module nibble_dram_seq
  import dseq_pkg::*;
#(
  parameter int ROW_W = 8,
  parameter int COL_W = 8,
  parameter int NIB_W = 4,
  localparam int AW   = ROW_W + COL_W - 1,
  localparam int DW   = 2 * NIB_W,
  localparam int MA_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             line_active,
  input  logic             vid_valid,
  output logic             vid_ready,
  input  logic [AW-1:0]    vid_addr,
  input  logic             cpu_valid,
  output logic             cpu_ready,
  input  logic [AW-1:0]    cpu_addr,
  input  logic             cpu_we,
  input  logic [DW-1:0]    cpu_wdata,
  output logic             rd_valid,
  output logic             rd_owner,
  output logic [DW-1:0]    rd_data,
  output logic [MA_W-1:0]  dram_a,
  output logic             dram_ras_n,
  output logic             dram_cas_n,
  output logic             dram_we_n,
  output logic             dram_dq_oe,
  output logic [NIB_W-1:0] dram_dq_o,
  input  logic [NIB_W-1:0] dram_dq_i
);
  logic [PH_W-1:0] ph;
  logic            d_v, d_we, q_v, q_we;
  logic [AW-1:0]   d_addr, q_addr;
  logic [DW-1:0]   d_wdata, q_wdata;
  owner_e          d_own, q_own, rd_own_e;

  dseq_slot_ctl #(.AW(AW), .DW(DW)) u_slot (
    .clk(clk), .rst_n(rst_n), .mode(dmode_e'(mode)), .line_active(line_active),
    .vid_valid(vid_valid), .vid_addr(vid_addr),
    .cpu_valid(cpu_valid), .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
    .vid_ready(vid_ready), .cpu_ready(cpu_ready), .ph(ph),
    .d_v(d_v), .d_we(d_we), .d_addr(d_addr), .d_wdata(d_wdata), .d_own(d_own),
    .q_v(q_v), .q_we(q_we), .q_addr(q_addr), .q_wdata(q_wdata), .q_own(q_own)
  );

  dseq_strobe_gen #(.ROW_W(ROW_W), .COL_W(COL_W), .NIB_W(NIB_W)) u_strobe (
    .clk(clk), .rst_n(rst_n), .ph(ph),
    .d_v(d_v), .d_we(d_we), .d_addr(d_addr), .d_wdata(d_wdata),
    .q_v(q_v), .q_we(q_we), .q_addr(q_addr), .q_wdata(q_wdata),
    .dram_a(dram_a), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_dq_oe(dram_dq_oe), .dram_dq_o(dram_dq_o)
  );

  dseq_nibble_join #(.NIB_W(NIB_W)) u_join (
    .clk(clk), .rst_n(rst_n), .ph(ph),
    .q_v(q_v), .q_we(q_we), .q_own(q_own), .dq_i(dram_dq_i),
    .rd_valid(rd_valid), .rd_owner(rd_own_e), .rd_data(rd_data)
  );

  assign rd_owner = rd_own_e;
endmodule

// File: tb/nibble_dram_seq_test.sv
module nibble_dram_seq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode;
  logic        line_active;
  logic        vid_valid, vid_ready, cpu_valid, cpu_ready, cpu_we;
  logic [14:0] vid_addr, cpu_addr;
  logic [7:0]  cpu_wdata, rd_data;
  logic        rd_valid, rd_owner;
  logic [7:0]  dram_a;
  logic        dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
  logic [3:0]  dram_dq_o;
  logic [3:0]  dq_i_r = 4'h0;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  nibble_dram_seq uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .line_active(line_active),
    .vid_valid(vid_valid), .vid_ready(vid_ready), .vid_addr(vid_addr),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_addr(cpu_addr),
    .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
    .rd_valid(rd_valid), .rd_owner(rd_owner), .rd_data(rd_data),
    .dram_a(dram_a), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_dq_oe(dram_dq_oe), .dram_dq_o(dram_dq_o),
    .dram_dq_i(dq_i_r)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---- memory model: nibble store keyed by {row, column} ----
  logic [3:0] mem [int];
  logic [7:0] shadow [int];

  function automatic logic [3:0] nib_init(input int k);
    int t;
    t = k ^ (k >> 5) ^ 3;
    return t[3:0];
  endfunction

  function automatic logic [3:0] mem_rd(input int k);
    if (mem.exists(k)) return mem[k];
    return nib_init(k);
  endfunction

  function automatic logic [7:0] exp_byte(input logic [14:0] ba);
    if (shadow.exists(int'(ba))) return shadow[int'(ba)];
    return {nib_init(int'({ba, 1'b1})), nib_init(int'({ba, 1'b0}))};
  endfunction

  logic       p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1;
  logic [7:0] p_a = 8'h0, m_row = 8'h0;
  int         cas_cnt = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_ras && !dram_ras_n) begin
        chk(dram_a == p_a, "R3", "row address setup", dram_a, p_a);
        m_row   = dram_a;
        cas_cnt = 0;
      end
      if (p_cas && !dram_cas_n) begin
        chk(!dram_ras_n, "R2", "column strobe with row closed", dram_ras_n, 0);
        chk(dram_a == p_a, "R3", "column address setup", dram_a, p_a);
        cas_cnt++;
        if (!dram_we_n) begin
          chk(dram_dq_oe, "R8", "data drive at write latch", dram_dq_oe, 1);
          mem[int'({m_row, dram_a})] = dram_dq_o;
        end else begin
          dq_i_r = mem_rd(int'({m_row, dram_a}));
        end
      end
      if (!p_ras && dram_ras_n)
        chk(cas_cnt == 2, "R2", "column strobes per row", cas_cnt, 2);
      if (!p_ras && !dram_ras_n)
        chk(dram_we_n == p_we, "R8", "write enable steady", dram_we_n, p_we);
    end
    p_ras = dram_ras_n; p_cas = dram_cas_n; p_we = dram_we_n; p_a = dram_a;
  end

  // expected {ras_n, cas_n, we_n, oe} per slot cycle
  function automatic logic [3:0] exp_sig(input int p, input bit we);
    case (p)
      0:       return 4'b1110;
      1:       return {2'b01, ~we, 1'b0};
      2, 4:    return {2'b01, ~we, we};
      3, 5:    return {2'b00, ~we, we};
      6:       return {2'b11, ~we, 1'b0};
      default: return 4'b1110;
    endcase
  endfunction

  task automatic xfer(input bit by_cpu, input logic [14:0] addr, input bit we,
                      input logic [7:0] wd);
    logic [7:0] ex, ea;
    logic [3:0] sig;
    ex = exp_byte(addr);
    @(negedge clk);
    if (by_cpu) begin
      cpu_valid = 1'b1; cpu_addr = addr; cpu_we = we; cpu_wdata = wd;
    end else begin
      vid_valid = 1'b1; vid_addr = addr;
    end
    while (!(by_cpu ? cpu_ready : vid_ready)) @(negedge clk);
    @(negedge clk);
    cpu_valid = 1'b0; vid_valid = 1'b0;
    for (int p = 0; p < 8; p++) begin
      sig = {dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe};
      chk(sig == exp_sig(p, we), "R1 R2 R8", $sformatf("strobes cycle %0d", p),
          sig, exp_sig(p, we));
      if (p < 2)      ea = addr[14:7];
      else if (p < 4) ea = {addr[6:0], 1'b0};
      else            ea = {addr[6:0], 1'b1};
      chk(dram_a == ea, "R3", $sformatf("address cycle %0d", p), dram_a, ea);
      if (we && p >= 2 && p <= 5)
        chk(dram_dq_o == (p < 4 ? wd[3:0] : wd[7:4]), "R8",
            $sformatf("write nibble cycle %0d", p), dram_dq_o, p < 4 ? wd[3:0] : wd[7:4]);
      if (p < 7) begin
        chk(!rd_valid, "R4", "early read valid", rd_valid, 0);
        @(negedge clk);
      end else if (we) begin
        chk(!rd_valid, "R8", "read valid after write", rd_valid, 0);
      end else begin
        chk(rd_valid, "R4", "read valid in cycle 7", rd_valid, 1);
        chk(rd_data == ex, "R4", "read byte", rd_data, ex);
        chk(rd_owner == by_cpu, "R4", "read owner tag", rd_owner, by_cpu);
      end
    end
    if (we) shadow[int'(addr)] = wd;
  endtask

  task automatic grants(input logic [1:0] m, input bit act, input int nslots,
                        input int ev, input int ec, input bit alt, input string req);
    int nv, nc, last;
    bit alt_ok;
    nv = 0; nc = 0; last = -1; alt_ok = 1'b1;
    @(negedge clk);
    mode = m; line_active = act;
    vid_valid = 1'b1; vid_addr = 15'h0123;
    cpu_valid = 1'b1; cpu_addr = 15'h0456; cpu_we = 1'b0;
    repeat (8) @(negedge clk);
    repeat (nslots * 8) begin
      @(negedge clk);
      if (vid_ready) begin if (last == 0) alt_ok = 1'b0; last = 0; nv++; end
      if (cpu_ready) begin if (last == 1) alt_ok = 1'b0; last = 1; nc++; end
    end
    vid_valid = 1'b0; cpu_valid = 1'b0;
    repeat (9) @(negedge clk);
    chk(nv == ev, req, "video grants", nv, ev);
    chk(nc == ec, req, "cpu grants", nc, ec);
    if (alt) chk(alt_ok, req, "alternating owners", alt_ok, 1);
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int unsigned s;
    logic [14:0] a;
    bit          narrow, by_cpu, we;
    s = $urandom(32'd4242);
    rst_n = 1'b0; mode = 2'b01; line_active = 1'b1;
    vid_valid = 1'b0; cpu_valid = 1'b0; cpu_we = 1'b0;
    vid_addr = '0; cpu_addr = '0; cpu_wdata = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk({dram_ras_n, dram_cas_n, dram_we_n} == 3'b111, "R10", "strobes in reset",
        {dram_ras_n, dram_cas_n, dram_we_n}, 3'b111);
    chk(!dram_dq_oe && !rd_valid, "R10", "drive and valid in reset",
        {dram_dq_oe, rd_valid}, 0);
    rst_n = 1'b1;
    // R5 first slot after reset is video, the next one CPU
    chk(vid_ready && !cpu_ready, "R5", "first grant", {vid_ready, cpu_ready}, 2'b10);
    repeat (8) @(negedge clk);
    chk(!vid_ready && cpu_ready, "R5", "second grant", {vid_ready, cpu_ready}, 2'b01);
    chk({dram_ras_n, dram_cas_n} == 2'b11, "R9", "no strobes in empty slot",
        {dram_ras_n, dram_cas_n}, 2'b11);

    // directed corners: lowest and highest address, both masters
    xfer(1'b1, 15'h0000, 1'b1, 8'hA5);
    xfer(1'b1, 15'h7FFF, 1'b1, 8'h3C);
    xfer(1'b0, 15'h0000, 1'b0, 8'h00);
    xfer(1'b0, 15'h7FFF, 1'b0, 8'h00);
    xfer(1'b1, 15'h0080, 1'b0, 8'h00);

    // R9 idle slots without requests
    @(negedge clk);
    mode = 2'b00;
    begin
      bit quiet;
      quiet = 1'b1;
      repeat (16) begin
        @(negedge clk);
        if (!dram_ras_n || !dram_cas_n || vid_ready) quiet = 1'b0;
      end
      chk(quiet, "R9 R7", "no strobes without request", quiet, 1);
    end

    grants(2'b01, 1'b1, 16, 8, 8, 1'b1, "R5");
    grants(2'b10, 1'b1, 16, 16, 0, 1'b0, "R6");
    grants(2'b11, 1'b1, 16, 16, 0, 1'b0, "R6");
    grants(2'b10, 1'b0, 16, 0, 16, 1'b0, "R7");
    grants(2'b00, 1'b1, 16, 0, 16, 1'b0, "R7");

    // constrained random traffic
    for (int i = 0; i < 60; i++) begin
      narrow = $urandom % 2;
      @(negedge clk);
      mode = narrow ? 2'b01 : 2'b00;
      line_active = 1'b1;
      a = 15'(($urandom % 8) * 4099);
      by_cpu = narrow ? ($urandom % 2) : 1'b1;
      we = by_cpu ? ($urandom % 2) : 1'b0;
      xfer(by_cpu, a, we, 8'($urandom));
    end
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule